// File: doc/BRIEF.md
# Two-Stage Shift-Add Times-Fifteen Multiplier

This block multiplies an unsigned operand by the constant fifteen. It uses no multiplier. The product is the sum of the operand shifted left by three, by two and by one, plus the operand itself. Each adder is a ripple chain of single-bit full-adder cells with carry-in tied to zero. The final carry is dropped, so the result wraps modulo 2^WIDTH.

The three additions are split across two registered stages, which shortens the longest combinational path:

- **First stage:** two partial sums form in parallel. One is the operand shifted by two plus the operand shifted by three. The other is the operand shifted by one plus the operand.
- **Second stage:** a third adder combines the two registered partial sums, and a final register captures the result.

An operand is taken only when the first stage holds nothing. As a result, at most one new operand enters every two clock cycles, and a strobe that arrives while an operand is still in flight is dropped. The reset input is active-low and asynchronous. Inside the block it is released in step with the clock.

Top module: `mul15_pipe`

## Requirements
- R1: When `res_vld` is high, `res` equals (operand × 15) mod 2^WIDTH for the operand accepted two clock edges earlier. This holds for every WIDTH-bit operand.
- R2: An operand is accepted at a rising edge when `op_vld` is high and no operand is in flight. `res_vld` is then high after the second rising edge that follows.
- R3: `res_vld` is a single-cycle pulse. It is never high in two consecutive cycles.
- R4: An `op_vld` strobe in the cycle right after an accepted operand is ignored. It produces no result and does not disturb the pending result.
- R5: While `rst_n` is low, `res` is 0 and `res_vld` is 0. Asserting reset mid-operation discards any operand in flight.
- R6: `res` keeps its value in every cycle in which `res_vld` is low.
- R7: With `op_vld` held high continuously, every other cycle's operand is accepted. This yields one result every two cycles.
- R8: Results whose full product exceeds the width wrap. For operand 255 at WIDTH=8, the result is 241.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | WIDTH | Unsigned operand |
| op_vld | input | 1 | Operand strobe |
| res | output | WIDTH | Registered product, low WIDTH bits |
| res_vld | output | 1 | One-cycle result strobe |

## Verification
The hardest situation to reach is a strobe arriving exactly one cycle after an accepted operand, when the first stage is occupied and the strobe must be dropped. The stimulus creates it in two ways. It issues deliberate back-to-back strobe pairs. It also holds the strobe high for long runs with a new operand every cycle. In both cases only the operands on accepted cycles are queued as expected results. A reset pulled while an operand sits in the first stage checks that the operand disappears without ever producing a strobe.

// File: rtl/mul15_pkg.sv
package mul15_pkg;
  localparam int unsigned M15_DEF_W   = 8;
  localparam int unsigned M15_SYNC_FF = 2;
endpackage

// File: rtl/m15_fa_cell.sv
module m15_fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a | b));
endmodule

// File: rtl/m15_ripple_add.sv
module m15_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_full
      m15_fa_cell u_cell (
        .a  (a[i]),
        .b  (b[i]),
        .ci (carry[i]),
        .s  (s[i]),
        .co (carry[i+1])
      );
    end else begin : g_top
      assign s[i] = a[i] ^ b[i] ^ carry[i];
    end
  end
endmodule

// File: rtl/m15_rst_sync.sv
module m15_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/m15_stage1.sv
module m15_stage1 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] op,
  input  logic         op_vld,
  output logic [W-1:0] psum_hi,
  output logic [W-1:0] psum_lo,
  output logic         busy
);
  logic [W-1:0] sum_hi, sum_lo;
  logic [W-1:0] hi_d, lo_d;
  logic         take;
  logic         busy_d;

  m15_ripple_add #(.W(W)) u_add_hi (
    .a (op << 2),
    .b (op << 3),
    .s (sum_hi)
  );

  m15_ripple_add #(.W(W)) u_add_lo (
    .a (op << 1),
    .b (op),
    .s (sum_lo)
  );

  always_comb begin
    take   = op_vld & ~busy;
    busy_d = take;
    hi_d   = take ? sum_hi : psum_hi;
    lo_d   = take ? sum_lo : psum_lo;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      psum_hi <= '0;
      psum_lo <= '0;
      busy    <= 1'b0;
    end else begin
      psum_hi <= hi_d;
      psum_lo <= lo_d;
      busy    <= busy_d;
    end
  end

  // R4: an occupied first stage always drains before the next operand
  p_no_double_take_r4: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> !busy);
endmodule

// File: rtl/m15_stage2.sv
module m15_stage2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] psum_hi,
  input  logic [W-1:0] psum_lo,
  input  logic         busy,
  output logic [W-1:0] res,
  output logic         res_vld
);
  logic [W-1:0] total;
  logic [W-1:0] res_d;
  logic         vld_d;

  m15_ripple_add #(.W(W)) u_add_fin (
    .a (psum_hi),
    .b (psum_lo),
    .s (total)
  );

  always_comb begin
    vld_d = busy;
    res_d = busy ? total : res;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res     <= res_d;
      res_vld <= vld_d;
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_q)
    res_vld |=> !res_vld);
endmodule

// File: rtl/mul15_pipe.sv
module mul15_pipe
  import mul15_pkg::*;
#(
  parameter int unsigned WIDTH = M15_DEF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op,
  input  logic             op_vld,
  output logic [WIDTH-1:0] res,
  output logic             res_vld
);
  localparam int unsigned PW = WIDTH + 4;

  logic             rst_q;
  logic [WIDTH-1:0] psum_hi, psum_lo;
  logic             busy;

  m15_rst_sync #(.STAGES(M15_SYNC_FF)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  m15_stage1 #(.W(WIDTH)) u_s1 (
    .clk     (clk),
    .rst_q   (rst_q),
    .op      (op),
    .op_vld  (op_vld),
    .psum_hi (psum_hi),
    .psum_lo (psum_lo),
    .busy    (busy)
  );

  m15_stage2 #(.W(WIDTH)) u_s2 (
    .clk     (clk),
    .rst_q   (rst_q),
    .psum_hi (psum_hi),
    .psum_lo (psum_lo),
    .busy    (busy),
    .res     (res),
    .res_vld (res_vld)
  );

  // R1 / R8: wrapped product of the operand seen two edges back
  logic [PW-1:0] full_prod;
  assign full_prod = PW'(op) * PW'(15);

  p_product_r1: assert property (@(posedge clk) disable iff (!rst_q)
    res_vld |-> res == $past(full_prod[WIDTH-1:0], 2));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (op_vld && !busy) |=> ##1 res_vld);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !res_vld |-> $stable(res));

  p_reset_r5: assert property (@(posedge clk)
    !rst_n |-> (!res_vld && res == '0));
endmodule

// File: tb/mul15_pipe_bench.sv
`timescale 1ns/1ps
module mul15_pipe_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op;
  logic         op_vld;
  logic [W-1:0] res;
  logic         res_vld;

  int errs   = 0;
  int checks = 0;
  int cyc    = 0;
  logic [W-1:0] exp_q[$];
  int           due_q[$];
  logic [W-1:0] last_res = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mul15_pipe #(.WIDTH(W)) u_mul15_pipe (
    .clk (clk), .rst_n (rst_n), .op (op), .op_vld (op_vld),
    .res (res), .res_vld (res_vld)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] v);
    logic [W+3:0] p;
    p = {4'b0, v} * 15;
    return p[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // monitor: compares results against the scoreboard (R1, R2, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_vld) begin
        if (exp_q.size() == 0) begin
          check(0, "R4 unexpected result", int'(res), -1);
        end else begin
          logic [W-1:0] e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          check(res == e, "R1 product", int'(res), int'(e));
          check(cyc == d, "R2 latency", cyc, d);
        end
        last_res = res;
      end else begin
        check(res == last_res, "R6 hold", int'(res), int'(last_res));
      end
    end
  end

  // driver: one operand, expected in the queue only if accepted
  task automatic drive(input logic [W-1:0] v, input bit vld, input bit accepted);
    op     = v;
    op_vld = vld;
    if (accepted) begin
      exp_q.push_back(model(v));
      due_q.push_back(cyc + 2);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0, 1'b0, 1'b0);
  endtask

  task automatic drained(input string req);
    idle(4);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #2_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n  = 1'b1;
    op     = '0;
    op_vld = 1'b0;
    #2 rst_n = 1'b0;
    @(negedge clk);
    check(res == '0, "R5 reset res", int'(res), 0);
    check(res_vld == 1'b0, "R5 reset vld", int'(res_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1: exhaustive sweep, one operand every other cycle
    for (int v = 0; v < (1 << W); v++) begin
      drive(W'(v), 1'b1, 1'b1);
      idle(1);
    end
    drained("R1 sweep drained");

    // R8: wrap boundary
    drive(8'd255, 1'b1, 1'b1);
    idle(2);
    check(last_res == 8'd241, "R8 wrap", int'(last_res), 241);
    drained("R8 drained");

    // R4: second strobe while the first operand is in flight
    drive(8'd7, 1'b1, 1'b1);
    drive(8'd200, 1'b1, 1'b0);
    idle(2);
    check(last_res == model(8'd7), "R4 pending result kept", int'(last_res), int'(model(8'd7)));
    drained("R4 ignored strobe");

    // R7: strobe held high, a new operand every cycle
    for (int k = 0; k < 20; k++) drive(W'(k * 37 + 3), 1'b1, (k % 2) == 0);
    drained("R7 throughput");

    // R3: back-to-back accepted operands keep single-cycle pulses
    for (int k = 0; k < 6; k++) begin
      drive(W'(k + 100), 1'b1, 1'b1);
      drive(W'(k + 50), 1'b0, 1'b0);
    end
    drained("R3 pulses");

    // R5: reset while an operand sits in the first stage
    drive(8'd99, 1'b1, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check(res == '0, "R5 mid reset res", int'(res), 0);
    check(res_vld == 1'b0, "R5 mid reset vld", int'(res_vld), 0);
    last_res = '0;
    @(negedge clk);
    op_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    check(res == '0, "R5 operand discarded", int'(res), 0);

    drive(8'd17, 1'b1, 1'b1);
    drained("R5 restart");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule